// File: doc/BRIEF.md
# Masked Rectangle Fill Engine

The engine paints an axis-aligned rectangle into a byte-addressed framebuffer. It takes the following inputs:

- a destination base pointer;
- a row stride in bytes;
- an x/y origin and a width/height, with horizontal values given in pixels;
- a pixel-depth scale;
- an 8-bit colour and an 8-bit plane mask;
- an operation code.

Horizontal pixel values are converted to bytes by a left shift of 0, 1 or 2. The engine then visits every byte of the rectangle in row-major order. On each byte it does a read-modify-write through a byte-wide memory port, and the new value is a masked fill, a masked xor or an inversion of the old byte.

A one-cycle `start` pulse latches all operands and raises `busy`. Further starts are ignored until the job ends. A one-cycle `done` pulse marks completion.

A null base pointer selects a built-in default framebuffer base. A plain fill with a full plane mask skips the read phase and writes the colour directly. A rectangle with zero width or zero height finishes at once without touching memory.

Top module: `rect_fill_engine`

## Requirements
- R1: The first byte accessed is at base + y*stride + (x << scale), all in bytes; `depthScale` values 0, 1 and 2 select shifts of 0, 1 and 2, and the value 3 is treated as 2.
- R2: Each row touches exactly width << scale consecutive bytes, so a job accesses (width << scale) * height bytes.
- R3: When `dstBase` is zero, the base used is the parameter `DEFAULT_BASE`.
- R4: With `opSel` = 2'b00 (fill), each byte becomes (colour & mask) | (old & ~mask).
- R5: With `opSel` = 2'b01 (xor), each byte becomes old ^ (colour & mask).
- R6: With `opSel` = 2'b10 or 2'b11 (invert), each byte becomes ~old and the mask and colour have no effect.
- R7: Bytes are visited left to right within a row, and each row starts exactly one stride after the previous row start.
- R8: A fill whose mask is 8'hFF issues no reads and writes the colour directly.
- R9: A zero width or zero height causes no memory access, and `done` is high in the cycle after the start edge.
- R10: A `start` pulse while `busy` is high has no effect on the running job.
- R11: A write in read-modify-write mode is issued only after the read data for that byte has arrived with `memRvalid`; `memRd` and `memWr` are never high together.
- R12: `done` is a single-cycle pulse after the last write, `busy` is low after it, and no memory access happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; operands are latched on it |
| dstBase | input | 32 | Destination base byte address; 0 selects DEFAULT_BASE |
| dstStride | input | 14 | Row stride in bytes |
| dstX | input | 14 | Left edge in pixels |
| dstY | input | 14 | Top row |
| width | input | 14 | Width in pixels |
| height | input | 14 | Height in rows |
| depthScale | input | 2 | Pixel-to-byte shift (0, 1, 2; 3 acts as 2) |
| fillColor | input | 8 | Colour byte |
| planeMask | input | 8 | Plane mask |
| opSel | input | 2 | 00 fill, 01 xor, 1x invert |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| memRd | output | 1 | Read request for memAddr |
| memWr | output | 1 | Write of memWdata to memAddr |
| memAddr | output | 32 | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with memRvalid |
| memRvalid | input | 1 | Read data valid, one cycle, at least one cycle after memRd |

## Verification
The bench runs random rectangles against a byte memory with a variable read latency, and compares the whole memory with a reference painter after each job. Several corner cases are aimed at directly:

- Rows whose start overlaps the previous row's end, which catch a design that advances by width instead of stride, since the wrong bytes change.
- The full-mask fill, where any read counted shows the fast path is missing.
- A null base, which a design without the default would paint near address zero.
- Zero-size jobs, where a design that runs a row anyway writes memory or misses the early `done`.
- A second `start` while busy, which a design that relatches operands would answer by painting a different rectangle.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef struct packed {
    logic load;     // latch operands and start address
    logic capture;  // store returned read byte
    logic advance;  // step to next byte of the rectangle
  } rfe_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_WAIT  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } rfe_state_e;

  localparam logic [1:0] OP_FILL = 2'b00;
  localparam logic [1:0] OP_XOR  = 2'b01;
endpackage

// File: rtl/rfe_datapath.sv
module rfe_datapath
  import rfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int COORD_W = 14,
  parameter logic [ADDR_W-1:0] DEFAULT_BASE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  rfe_strobe_t        strb,
  input  logic [ADDR_W-1:0]  dstBase,
  input  logic [COORD_W-1:0] dstStride,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [1:0]         depthScale,
  input  logic [7:0]         fillColor,
  input  logic [7:0]         planeMask,
  input  logic [1:0]         opSel,
  input  logic [7:0]         memRdata,
  output logic               emptyNow,
  output logic               fastNow,
  output logic               fastQ,
  output logic               lastByte,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [7:0]         wData
);
  localparam int XW = COORD_W + 2;
  localparam int PW = 2 * COORD_W;

  logic [1:0]         scaleEff;
  logic [XW-1:0]      xBytes, wBytesNow;
  logic [PW-1:0]      rowOff;
  logic [ADDR_W-1:0]  baseSel, startAddr;

  logic [COORD_W-1:0] strideQ, heightQ;
  logic [XW-1:0]      wBytesQ, colCnt;
  logic [COORD_W-1:0] rowCnt;
  logic [7:0]         colorQ, maskQ, oldQ;
  logic [1:0]         opQ;
  logic [ADDR_W-1:0]  rowPtr, bytePtr;
  logic               rowEnd;

  assign scaleEff  = (depthScale == 2'd3) ? 2'd2 : depthScale;
  assign xBytes    = XW'(dstX) << scaleEff;
  assign wBytesNow = XW'(width) << scaleEff;
  assign rowOff    = PW'(dstY) * PW'(dstStride);
  assign baseSel   = (dstBase == '0) ? DEFAULT_BASE : dstBase;
  assign startAddr = baseSel + ADDR_W'(rowOff) + ADDR_W'(xBytes);
  assign emptyNow  = (width == '0) || (height == '0);
  assign fastNow   = (opSel == OP_FILL) && (planeMask == 8'hFF);

  assign rowEnd   = (colCnt == wBytesQ - XW'(1));
  assign lastByte = rowEnd && (rowCnt == heightQ - COORD_W'(1));
  assign curAddr  = bytePtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strideQ <= '0;
      heightQ <= '0;
      wBytesQ <= '0;
      colorQ  <= '0;
      maskQ   <= '0;
      opQ     <= '0;
      fastQ   <= 1'b0;
      rowPtr  <= '0;
      bytePtr <= '0;
      colCnt  <= '0;
      rowCnt  <= '0;
      oldQ    <= '0;
    end else begin
      if (strb.load) begin
        strideQ <= dstStride;
        heightQ <= height;
        wBytesQ <= wBytesNow;
        colorQ  <= fillColor;
        maskQ   <= planeMask;
        opQ     <= opSel;
        fastQ   <= fastNow;
        rowPtr  <= startAddr;
        bytePtr <= startAddr;
        colCnt  <= '0;
        rowCnt  <= '0;
      end else if (strb.advance) begin
        if (rowEnd) begin
          colCnt  <= '0;
          rowCnt  <= rowCnt + COORD_W'(1);
          rowPtr  <= rowPtr + ADDR_W'(strideQ);
          bytePtr <= rowPtr + ADDR_W'(strideQ);
        end else begin
          colCnt  <= colCnt + XW'(1);
          bytePtr <= bytePtr + ADDR_W'(1);
        end
      end
      if (strb.capture) oldQ <= memRdata;
    end
  end

  always_comb begin
    if (fastQ) begin
      wData = colorQ;
    end else begin
      unique case (opQ)
        OP_FILL: wData = (colorQ & maskQ) | (oldQ & ~maskQ);
        OP_XOR:  wData = oldQ ^ (colorQ & maskQ);
        default: wData = ~oldQ;
      endcase
    end
  end

  // R7: within a row, the next byte follows the current one
  assert_col_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.load && !rowEnd) |=> (curAddr == $past(curAddr) + ADDR_W'(1)));
  // R7: a new row begins one stride after the previous row start
  assert_row_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.load && rowEnd) |=> (curAddr == $past(rowPtr) + ADDR_W'($past(strideQ))));
endmodule

// File: rtl/rfe_ctrl.sv
module rfe_ctrl
  import rfe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        emptyNow,
  input  logic        fastNow,
  input  logic        fastQ,
  input  logic        lastByte,
  input  logic        memRvalid,
  output rfe_strobe_t strb,
  output logic        busy,
  output logic        done,
  output logic        memRd,
  output logic        memWr
);
  rfe_state_e state, stateNext;
  logic haveData;

  always_comb begin
    stateNext = state;
    strb = '0;
    unique case (state)
      S_IDLE: if (start) begin
        strb.load = 1'b1;
        if (emptyNow)     stateNext = S_DONE;
        else if (fastNow) stateNext = S_WRITE;
        else              stateNext = S_READ;
      end
      S_READ: stateNext = S_WAIT;
      S_WAIT: if (memRvalid) begin
        strb.capture = 1'b1;
        stateNext = S_WRITE;
      end
      S_WRITE: begin
        strb.advance = 1'b1;
        if (lastByte)   stateNext = S_DONE;
        else if (fastQ) stateNext = S_WRITE;
        else            stateNext = S_READ;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      haveData <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.capture)      haveData <= 1'b1;
      else if (state == S_WRITE) haveData <= 1'b0;
    end
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);
  assign memRd = (state == S_READ);
  assign memWr = (state == S_WRITE);

  // R11: read-modify-write only writes once the read byte arrived
  assert_wr_after_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !fastQ) |-> haveData);
  // R11: never read and write in the same cycle
  assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R12: done lasts exactly one cycle and busy drops after it
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R12: no memory traffic while idle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !memWr));
  // R10: operands are only loaded from idle
  assert_no_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !busy);
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int COORD_W = 14,
  parameter logic [ADDR_W-1:0] DEFAULT_BASE = 32'h0000_0800
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  dstBase,
  input  logic [COORD_W-1:0] dstStride,
  input  logic [COORD_W-1:0] dstX,
  input  logic [COORD_W-1:0] dstY,
  input  logic [COORD_W-1:0] width,
  input  logic [COORD_W-1:0] height,
  input  logic [1:0]         depthScale,
  input  logic [7:0]         fillColor,
  input  logic [7:0]         planeMask,
  input  logic [1:0]         opSel,
  output logic               busy,
  output logic               done,
  output logic               memRd,
  output logic               memWr,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [7:0]         memWdata,
  input  logic [7:0]         memRdata,
  input  logic               memRvalid
);
  rfe_strobe_t strb;
  logic emptyNow, fastNow, fastQ, lastByte;

  rfe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .emptyNow(emptyNow), .fastNow(fastNow), .fastQ(fastQ), .lastByte(lastByte),
    .memRvalid(memRvalid), .strb(strb), .busy(busy), .done(done),
    .memRd(memRd), .memWr(memWr)
  );

  rfe_datapath #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .DEFAULT_BASE(DEFAULT_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dstBase(dstBase), .dstStride(dstStride), .dstX(dstX), .dstY(dstY),
    .width(width), .height(height), .depthScale(depthScale),
    .fillColor(fillColor), .planeMask(planeMask), .opSel(opSel),
    .memRdata(memRdata), .emptyNow(emptyNow), .fastNow(fastNow), .fastQ(fastQ),
    .lastByte(lastByte), .curAddr(memAddr), .wData(memWdata)
  );
endmodule

// File: tb/rect_fill_engine_bench.sv
module rect_fill_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_SIZE = 8192;
  localparam logic [31:0] DEF_BASE = 32'h0000_0800;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] dstBase = '0;
  logic [13:0] dstStride = '0, dstX = '0, dstY = '0, width = '0, height = '0;
  logic [1:0]  depthScale = '0, opSel = '0;
  logic [7:0]  fillColor = '0, planeMask = '0;
  logic busy, done, memRd, memWr;
  logic [31:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        memRvalid = 1'b0;

  int errors = 0, checks = 0;
  logic [7:0] mem [MEM_SIZE];
  logic [7:0] refMem [MEM_SIZE];

  // memory model activity
  logic        pend = 1'b0;
  int          latCnt = 0;
  logic [31:0] pendAddr = '0;
  int rdCount = 0, wrCount = 0, doneCount = 0, cycles = 0;
  logic firstSeen = 1'b0, outOfRange = 1'b0;
  logic [31:0] firstAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rect_fill_engine u_rect_fill_engine (
    .clk(clk), .rstN(rstN), .start(start), .dstBase(dstBase), .dstStride(dstStride),
    .dstX(dstX), .dstY(dstY), .width(width), .height(height), .depthScale(depthScale),
    .fillColor(fillColor), .planeMask(planeMask), .opSel(opSel), .busy(busy), .done(done),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRvalid(memRvalid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    memRvalid <= 1'b0;
    if (memRd || memWr) begin
      if (memAddr >= MEM_SIZE) outOfRange <= 1'b1;
      if (!firstSeen) begin firstSeen <= 1'b1; firstAddr <= memAddr; end
    end
    if (memWr) begin
      wrCount <= wrCount + 1;
      mem[memAddr[12:0]] <= memWdata;
    end
    if (memRd) begin
      rdCount <= rdCount + 1;
      pend <= 1'b1;
      pendAddr <= memAddr;
      latCnt <= int'($urandom % 3);
    end else if (pend) begin
      if (latCnt == 0) begin
        memRvalid <= 1'b1;
        memRdata <= mem[pendAddr[12:0]];
        pend <= 1'b0;
      end else latCnt <= latCnt - 1;
    end
    if (done) doneCount <= doneCount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_start(input logic [31:0] b, input int st, input int x,
                                            input int y, input int sc);
    int s = (sc == 3) ? 2 : sc;
    return ((b == 0) ? DEF_BASE : b) + 32'(y * st) + 32'(x << s);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] old, input logic [7:0] c,
                                          input logic [7:0] m, input logic [1:0] op);
    if (op == 2'b00) return (c & m) | (old & ~m);
    if (op == 2'b01) return old ^ (c & m);
    return ~old;
  endfunction

  task automatic ref_paint(input logic [31:0] b, input int st, input int x, input int y,
                           input int w, input int h, input int sc, input logic [7:0] c,
                           input logic [7:0] m, input logic [1:0] op);
    int s = (sc == 3) ? 2 : sc;
    logic [31:0] row = exp_start(b, st, x, y, sc);
    for (int j = 0; j < h; j++) begin
      for (int i = 0; i < (w << s); i++) begin
        logic [31:0] a = row + 32'(i);
        refMem[a[12:0]] = exp_byte(refMem[a[12:0]], c, m, op);
      end
      row = row + 32'(st);
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0, firstBad = -1;
    for (int k = 0; k < MEM_SIZE; k++)
      if (mem[k] !== refMem[k]) begin bad++; if (firstBad < 0) firstBad = k; end
    check(bad == 0, req, $sformatf("memory image mismatch count (first at %0d)", firstBad), bad, 0);
  endtask

  // drive one job; extraStart pulses start again while busy with other operands
  task automatic run_job(input logic [31:0] b, input int st, input int x, input int y,
                         input int w, input int h, input int sc, input logic [7:0] c,
                         input logic [7:0] m, input logic [1:0] op, input bit extraStart,
                         input string req);
    int s = (sc == 3) ? 2 : sc;
    int n = (w << s) * h;
    int wait_cyc = 0;
    @(negedge clk);
    rdCount = 0; wrCount = 0; doneCount = 0; firstSeen = 1'b0; outOfRange = 1'b0;
    dstBase = b; dstStride = 14'(st); dstX = 14'(x); dstY = 14'(y);
    width = 14'(w); height = 14'(h); depthScale = 2'(sc);
    fillColor = c; planeMask = m; opSel = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check(done === 1'b1, "R9", "done in cycle after start", longint'(done), 1);
    end
    if (extraStart) begin
      @(negedge clk);
      dstBase = 32'd16; dstStride = 14'd3; dstX = 14'd1; dstY = 14'd1;
      width = 14'd5; height = 14'd2; opSel = 2'b10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy && wait_cyc < 5000) begin @(negedge clk); wait_cyc++; end
    check(wait_cyc < 5000, req, "job timeout", wait_cyc, 0);
    @(negedge clk);
    check(!busy && !done, "R12", "idle after done", longint'(busy), 0);
    check(doneCount == 1, "R12", "done pulse count", doneCount, 1);
    ref_paint(b, st, x, y, w, h, sc, c, m, op);
    compare_mem(req);
    check(wrCount == n, "R2", "write count", wrCount, n);
    check(!outOfRange, req, "access out of memory", longint'(outOfRange), 0);
    if ((op == 2'b00) && (m == 8'hFF))
      check(rdCount == 0, "R8", "reads on full-mask fill", rdCount, 0);
    else
      check(rdCount == n, "R11", "one read per byte", rdCount, n);
    if (n > 0)
      check(firstAddr == exp_start(b, st, x, y, sc), (b == 0) ? "R3" : "R1", "first address",
            firstAddr, exp_start(b, st, x, y, sc));
    else
      check(!firstSeen, "R9", "memory touched on empty job", longint'(firstSeen), 0);
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < MEM_SIZE; k++) begin
      mem[k] = 8'($urandom);
      refMem[k] = mem[k];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRd && !memWr, "R12", "reset state", longint'(busy), 0);
    rstN = 1'b1;
    // R4 masked fill, rows overlap stride smaller than row width (R7)
    run_job(32'd100, 6, 1, 2, 5, 3, 1, 8'hA5, 8'h3C, 2'b00, 1'b0, "R7");
    // R5 xor at 32-bit depth
    run_job(32'd300, 40, 2, 1, 3, 4, 2, 8'h5A, 8'hF0, 2'b01, 1'b0, "R5");
    // R6 invert, mask ignored, scale 3 behaves like 2
    run_job(32'd600, 20, 1, 0, 2, 3, 3, 8'h00, 8'h00, 2'b10, 1'b0, "R6");
    run_job(32'd700, 9, 0, 0, 4, 2, 0, 8'hFF, 8'h0F, 2'b11, 1'b0, "R6");
    // R8 full-mask fill fast path
    run_job(32'd900, 16, 3, 1, 6, 2, 0, 8'h77, 8'hFF, 2'b00, 1'b0, "R8");
    // R3 null base
    run_job(32'd0, 32, 4, 3, 3, 2, 1, 8'h81, 8'h99, 2'b00, 1'b0, "R3");
    // R9 empty jobs
    run_job(32'd50, 10, 1, 1, 0, 5, 0, 8'h11, 8'hFF, 2'b00, 1'b0, "R9");
    run_job(32'd50, 10, 1, 1, 4, 0, 1, 8'h11, 8'h0F, 2'b01, 1'b0, "R9");
    // R10 start while busy
    run_job(32'd1200, 12, 2, 2, 4, 3, 0, 8'hC3, 8'h66, 2'b01, 1'b1, "R10");
    // random mix (R1 R4 R5 R6)
    for (int t = 0; t < 30; t++) begin
      logic [31:0] b = ($urandom % 4 == 0) ? 32'd0 : 32'($urandom % 1024);
      run_job(b, 8 + int'($urandom % 57), int'($urandom % 16), int'($urandom % 21),
              1 + int'($urandom % 8), 1 + int'($urandom % 5), int'($urandom % 4),
              8'($urandom), ($urandom % 5 == 0) ? 8'hFF : 8'($urandom),
              2'($urandom), 1'b0, "R1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule